// File: doc/BRIEF.md
# Performance Counter with Overflow Interrupt and Privilege-Mode Filtering

This block is a single programmable hardware event counter paired with its 64-bit event-selector register. Each cycle it adds one to the count when the selected event input is high, unless counting is switched off globally or the selector forbids counting in the hart's current privilege mode. The selector holds one inhibit bit per mode: machine, supervisor, user, virtual supervisor and virtual user.

When the count wraps from all-ones to zero and the sticky overflow flag in the selector is still clear, the block sets the flag and requests a local counter-overflow interrupt for one cycle. While the flag stays set, later wraps raise no further request. The flag is brought out so that a shared overflow-summary register can gather it from every counter.

Software reaches the counter and the selector through a 32-bit register port, one half at a time. A write takes effect in the selector as soon as it lands, so the order in which the two halves are written does not matter. The low 20 selector bits are brought out as the event code for the event multiplexer outside this block.

Top module: `hpm_counter_unit`

## Requirements
- R1: After reset the counter, the selector, `ovf_flag` and `ovf_irq` are all zero.
- R2: With no inhibit in force, the counter increases by exactly one on every clock edge at which `event_in` is high, and holds otherwise.
- R3: Selector bits 62, 61, 60, 59 and 58 (bits 30 to 26 of the high half) block counting in M, S, U, VS and VU mode. The mode comes from `priv_lvl` and `virt_mode`: 11 is M whatever `virt_mode` is, 01 is S (VS when `virt_mode` is 1), and 00 is U (VU when `virt_mode` is 1). Level 10 never counts.
- R4: While `count_inhibit` is high the counter does not change, whatever the selector holds.
- R5: When an increment takes the counter from all-ones to zero and selector bit 63 (high-half bit 31, the overflow flag) is clear, the block sets that flag at the same edge and drives `ovf_irq` high for exactly one cycle.
- R6: A wrap while the overflow flag is already set leaves `ovf_irq` low and the flag set. Only a software write of 0 to that bit clears the flag.
- R7: A software write to the counter takes priority over an increment in the same cycle.
- R8: `csr_sel` 0 addresses the counter and 1 addresses the selector. `csr_hi` 0 selects bits 31:0 and 1 selects bits 63:32. A write changes only the addressed half, and the final selector contents do not depend on which half was written first.
- R9: Selector bits 57 to 48 (high-half bits 25 to 16) always read as zero, and writes to them are ignored. All other selector bits can be written and read back.
- R10: `ovf_flag` always equals selector bit 63, and `evt_code` always equals selector bits 19 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| event_in | input | 1 | Selected event, counted when high |
| count_inhibit | input | 1 | Global counting inhibit for this counter |
| priv_lvl | input | 2 | Current privilege level (11 M, 01 S, 00 U) |
| virt_mode | input | 1 | Virtualization active |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 counter, 1 selector |
| csr_hi | input | 1 | 0 low half, 1 high half |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for the addressed half |
| evt_code | output | 20 | Event identifier from the selector |
| ovf_flag | output | 1 | Sticky overflow flag, feeds the overflow summary |
| ovf_irq | output | 1 | One-cycle counter-overflow interrupt request |

## Verification
The mode filter is driven with a table of inhibit patterns crossed with privilege modes. Each pattern leaves one inhibit bit set while the hart runs in a neighbouring mode, so a swapped bit or a confusion between the virtual and non-virtual modes shows up as a wrong count. The overflow tests start the counter one step below all-ones, first with the flag clear and then with it set. This separates the first request from the suppressed repeat and from a wrap that is missing altogether. The register tests write the two selector halves in both orders, write every selector bit to one to expose the reserved field, and collide a counter write with an active event.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  localparam int unsigned SEL_W      = 64;
  localparam int unsigned HALF_W     = 32;
  localparam int unsigned EVT_W      = 20;
  localparam int unsigned OF_BIT     = 63;
  localparam int unsigned INH_TOP    = 62;
  localparam int unsigned INH_N      = 5;
  localparam logic [SEL_W-1:0] SEL_WR_MASK = 64'hFC00_FFFF_FFFF_FFFF;

  typedef enum logic [1:0] {
    PL_USER  = 2'b00,
    PL_SUPER = 2'b01,
    PL_RSVD  = 2'b10,
    PL_MACH  = 2'b11
  } priv_lvl_e;

  // inh = {M, S, U, VS, VU}
  function automatic logic mode_blocked(input logic [INH_N-1:0] inh,
                                        input logic [1:0] lvl,
                                        input logic virt);
    case (priv_lvl_e'(lvl))
      PL_MACH:  return inh[4];
      PL_SUPER: return virt ? inh[1] : inh[3];
      PL_USER:  return virt ? inh[0] : inh[2];
      default:  return 1'b1;
    endcase
  endfunction

  function automatic logic [SEL_W-1:0] merge_half(input logic [SEL_W-1:0] old,
                                                  input logic hi,
                                                  input logic [HALF_W-1:0] d);
    return hi ? {d, old[HALF_W-1:0]} : {old[SEL_W-1:HALF_W], d};
  endfunction
endpackage

// File: rtl/hpm_mode_filter.sv
module hpm_mode_filter
  import hpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INH_N-1:0] inh_bits,
  input  logic [1:0]       priv_lvl,
  input  logic             virt_mode,
  input  logic             count_inhibit,
  input  logic             event_in,
  output logic             count_ok
);
  logic blocked;
  assign blocked  = mode_blocked(inh_bits, priv_lvl, virt_mode);
  assign count_ok = event_in && !count_inhibit && !blocked;

  a_r3_rsvd_level: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_lvl == 2'b10) |-> !count_ok);
  a_r4_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    count_inhibit |-> !count_ok);
endmodule

// File: rtl/hpm_event_sel.sv
module hpm_event_sel
  import hpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              of_set,
  output logic [SEL_W-1:0]  sel_q
);
  logic [SEL_W-1:0] sel_wr_val;
  assign sel_wr_val = merge_half(sel_q, wr_hi, wr_data) & SEL_WR_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (wr_en) begin
      sel_q <= sel_wr_val;
      if (of_set && !wr_hi) sel_q[OF_BIT] <= 1'b1;
    end else if (of_set) begin
      sel_q[OF_BIT] <= 1'b1;
    end
  end

  a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q[57:48] == '0);
  a_r6_of_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[OF_BIT] && !(wr_en && wr_hi)) |=> sel_q[OF_BIT]);
endmodule

// File: rtl/hpm_count_core.sv
module hpm_count_core
  import hpm_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              of_now,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              wrap_evt,
  output logic              of_set,
  output logic              irq_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign wrap_evt = inc && !wr_en && (cnt_q == CNT_MAX);
  assign of_set   = wrap_evt && !of_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= of_set;
      if (wr_en)    cnt_q <= merge_half(cnt_q, wr_hi, wr_data);
      else if (inc) cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r5_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !of_now) |=> (irq_q && cnt_q == '0));
  a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && of_now) |=> !irq_q);
  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> cnt_q[HALF_W-1:0] == $past(wr_data));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_en) |=> $stable(cnt_q));
endmodule

// File: rtl/hpm_counter_unit.sv
module hpm_counter_unit
  import hpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        event_in,
  input  logic        count_inhibit,
  input  logic [1:0]  priv_lvl,
  input  logic        virt_mode,
  input  logic        csr_we,
  input  logic        csr_sel,
  input  logic        csr_hi,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic [19:0] evt_code,
  output logic        ovf_flag,
  output logic        ovf_irq
);
  localparam int unsigned CNT_W = 64;

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             count_ok, wrap_evt, of_set;
  logic             cnt_wr, sel_wr;

  assign cnt_wr = csr_we && !csr_sel;
  assign sel_wr = csr_we &&  csr_sel;

  hpm_mode_filter u_filter (
    .clk(clk), .rst_n(rst_n),
    .inh_bits(sel_q[INH_TOP -: INH_N]),
    .priv_lvl(priv_lvl), .virt_mode(virt_mode),
    .count_inhibit(count_inhibit), .event_in(event_in),
    .count_ok(count_ok)
  );

  hpm_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .inc(count_ok),
    .wr_en(cnt_wr), .wr_hi(csr_hi), .wr_data(csr_wdata),
    .of_now(sel_q[OF_BIT]),
    .cnt_q(cnt_q), .wrap_evt(wrap_evt), .of_set(of_set), .irq_q(ovf_irq)
  );

  hpm_event_sel u_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(sel_wr), .wr_hi(csr_hi),
    .wr_data(csr_wdata), .of_set(of_set), .sel_q(sel_q)
  );

  always_comb begin
    case ({csr_sel, csr_hi})
      2'b00:   csr_rdata = cnt_q[31:0];
      2'b01:   csr_rdata = cnt_q[63:32];
      2'b10:   csr_rdata = sel_q[31:0];
      default: csr_rdata = sel_q[63:32];
    endcase
  end

  assign evt_code = sel_q[EVT_W-1:0];
  assign ovf_flag = sel_q[OF_BIT];

  a_r10_flag_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ovf_flag || $past(csr_we && csr_sel && csr_hi));
  a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq);
endmodule

// File: tb/hpm_counter_unit_bench.sv
module hpm_counter_unit_bench;
  logic clk = 0, rst_n = 0;
  logic event_in = 0, count_inhibit = 0, virt_mode = 0;
  logic [1:0] priv_lvl = 2'b11;
  logic csr_we = 0, csr_sel = 0, csr_hi = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic [19:0] evt_code;
  logic ovf_flag, ovf_irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hpm_counter_unit u_hpm_counter_unit (.*);

  // {inh M,S,U,VS,VU ; priv ; virt ; expect count}
  localparam int NV = 12;
  localparam logic [8:0] VEC [NV] = '{
    {5'b00000, 2'b11, 1'b0, 1'b1}, {5'b10000, 2'b11, 1'b0, 1'b0},
    {5'b10000, 2'b01, 1'b0, 1'b1}, {5'b01000, 2'b01, 1'b0, 1'b0},
    {5'b01000, 2'b01, 1'b1, 1'b1}, {5'b00010, 2'b01, 1'b1, 1'b0},
    {5'b00100, 2'b00, 1'b0, 1'b0}, {5'b00100, 2'b00, 1'b1, 1'b1},
    {5'b00001, 2'b00, 1'b1, 1'b0}, {5'b00001, 2'b11, 1'b1, 1'b1},
    {5'b11111, 2'b10, 1'b0, 1'b0}, {5'b00000, 2'b10, 1'b0, 1'b0}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic hi, logic [31:0] d);
    csr_we = 1; csr_sel = sel; csr_hi = hi; csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic rd(logic sel, logic hi, output logic [31:0] d);
    csr_sel = sel; csr_hi = hi; #1 d = csr_rdata;
  endtask

  task automatic events(int n);
    event_in = 1;
    repeat (n) @(negedge clk);
    event_in = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    repeat (2) @(negedge clk);
    // R1 reset state
    rd(0, 0, d); check("R1 cnt lo", d, 0);
    rd(1, 1, d); check("R1 sel hi", d, 0);
    check("R1 flag/irq", {ovf_flag, ovf_irq}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3 table of mode patterns
    for (int i = 0; i < NV; i++) begin
      wr(1, 1, {1'b0, VEC[i][8:4], 26'b0});
      wr(0, 0, 0); wr(0, 1, 0);
      priv_lvl = VEC[i][3:2]; virt_mode = VEC[i][1];
      events(3);
      rd(0, 0, d);
      check($sformatf("R3 R2 vector %0d", i), d, VEC[i][0] ? 3 : 0);
    end
    priv_lvl = 2'b11; virt_mode = 0;
    wr(1, 1, 0);

    // R4 global inhibit
    wr(0, 0, 0);
    count_inhibit = 1; events(4); count_inhibit = 0;
    rd(0, 0, d); check("R4 inhibited count", d, 0);

    // R5 first wrap
    wr(0, 1, 32'hFFFF_FFFF); wr(0, 0, 32'hFFFF_FFFE);
    event_in = 1;
    @(negedge clk);
    check("R5 before wrap irq", ovf_irq, 0);
    @(negedge clk);
    event_in = 0;
    check("R5 irq at wrap", ovf_irq, 1);
    check("R5 flag set", ovf_flag, 1);
    rd(0, 0, d); rd(0, 1, d2); check("R5 wrapped to zero", {d2, d}, 0);
    rd(1, 1, d); check("R5 OF in high half bit31", d[31], 1);
    @(negedge clk);
    check("R5 irq one cycle", ovf_irq, 0);

    // R6 wrap with flag already set
    wr(0, 1, 32'hFFFF_FFFF); wr(0, 0, 32'hFFFF_FFFF);
    event_in = 1; @(negedge clk); event_in = 0;
    check("R6 no repeat irq", ovf_irq, 0);
    rd(0, 0, d); check("R6 counter wrapped", d, 0);
    check("R6 flag stays", ovf_flag, 1);
    wr(1, 1, 0);
    check("R6 flag cleared by write", ovf_flag, 0);

    // R7 counter write beats increment
    event_in = 1; csr_we = 1; csr_sel = 0; csr_hi = 0; csr_wdata = 32'h100;
    @(negedge clk);
    csr_we = 0; event_in = 0;
    rd(0, 0, d); check("R7 write wins", d, 32'h100);

    // R8 counter halves independent
    wr(0, 1, 32'h1234_5678); wr(0, 0, 32'h9ABC_DEF0);
    rd(0, 1, d); check("R8 cnt hi", d, 32'h1234_5678);
    rd(0, 0, d); check("R8 cnt lo", d, 32'h9ABC_DEF0);

    // R8/R10 selector order: low then high
    wr(1, 0, 32'h000A_BCDE); wr(1, 1, 32'h2000_0000);
    check("R10 evt_code lo-first", evt_code, 20'hABCDE);
    rd(1, 1, d); check("R8 sel hi lo-first", d, 32'h2000_0000);
    priv_lvl = 2'b01; wr(0, 0, 0); events(2);
    rd(0, 0, d); check("R8 S inhibit effective lo-first", d, 0);
    // high then low
    wr(1, 1, 32'h1000_0000); wr(1, 0, 32'h0001_2345);
    check("R10 evt_code hi-first", evt_code, 20'h12345);
    rd(1, 1, d); check("R8 sel hi hi-first", d, 32'h1000_0000);
    events(2);
    rd(0, 0, d); check("R8 S counts after hi-first", d, 2);
    priv_lvl = 2'b11;

    // R9 reserved field
    wr(1, 1, 32'hFFFF_FFFF); wr(1, 0, 32'hFFFF_FFFF);
    rd(1, 1, d); check("R9 reserved read zero", d, 32'hFC00_FFFF);
    rd(1, 0, d); check("R9 low half writable", d, 32'hFFFF_FFFF);
    check("R10 flag mirrors bit63", ovf_flag, 1);
    wr(1, 1, 0);
    check("R10 flag follows clear", ovf_flag, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule